// File: doc/BRIEF.md
# Bi-quinary decade counter

This block is a four-bit counter made of two independent sections that share one system clock. A one-bit section toggles on each count event of the low strobe and drives output bit 0 (QA). A three-bit modulo-five section advances on each count event of the high strobe and drives output bits 3..1 (QD, QC, QB). A count event is a high-to-low transition of a strobe. Each strobe is detected against a registered copy of itself, so both strobes are plain synchronous inputs.

Two gated control pairs override counting. When both clear inputs are high, the counter goes to zero. When both preset inputs are high, the counter goes to nine; this serves nine's complement BCD use, and the preset wins over the clear. The two sections are not linked inside the block. The surrounding logic links them. Feeding QA back into the high strobe gives a BCD decade count on the low strobe. Feeding QD back into the low strobe gives a symmetric divide-by-ten square wave on QA. Each external link adds one clock cycle of latency.

Top module: `bq_decade_counter`

## Requirements
- R1: While `rst_n` is low, `q_o` is 4'b0000 and both strobe history registers are cleared.
- R2: A clock edge that samples `cnt_a_i` low, when the previous edge sampled it high, toggles `q_o[0]` at that same edge, provided neither control pair is active.
- R3: A falling transition on `cnt_b_i`, detected the same way as in R2, moves `q_o[3:1]` through 000, 001, 010, 011, 100 and back to 000.
- R4: Rising transitions and steady levels on either strobe leave `q_o` unchanged.
- R5: At a clock edge where `clr0_a_i` and `clr0_b_i` are both high and the preset pair is not both high, `q_o` becomes 4'b0000.
- R6: At a clock edge where `set9_a_i` and `set9_b_i` are both high, `q_o` becomes 4'b1001 (QD=1, QC=0, QB=0, QA=1), whatever the clear pair does.
- R7: While either control pair is fully asserted, count events are dropped. A pair with only one input high has no effect on counting.
- R8: With `q_o[0]` wired to `cnt_b_i` and pulses on `cnt_a_i`, `q_o` steps through 0 to 9 in BCD and then wraps to 0.
- R9: With `q_o[3]` wired to `cnt_a_i` and pulses on `cnt_b_i`, `q_o[0]` is low for five pulses and then high for five pulses, repeating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, already released in step with `clk` |
| cnt_a_i | input | 1 | Count strobe for the divide-by-two section |
| cnt_b_i | input | 1 | Count strobe for the divide-by-five section |
| clr0_a_i | input | 1 | Clear-to-zero gate, first input |
| clr0_b_i | input | 1 | Clear-to-zero gate, second input |
| set9_a_i | input | 1 | Preset-to-nine gate, first input |
| set9_b_i | input | 1 | Preset-to-nine gate, second input |
| q_o | output | 4 | Count value: bit 3 QD, bit 2 QC, bit 1 QB, bit 0 QA |

## Verification
Strobe pulses of one-cycle and multi-cycle widths are applied to each section on its own. This separates true falling-edge detection from level sensing and from rising-edge counting. The control pairs are driven in every high and low combination. The single-input cases show that the gating is an AND, and the case with both pairs high shows that the preset has priority. Two looped configurations, decade and symmetric, run through several full cycles. They show the wrap at nine and the five-and-five duty of QA, including the one-cycle link latency.

// File: rtl/bq_pkg.sv
package bq_pkg;
  parameter int LO_MOD   = 2;
  parameter int HI_MOD   = 5;
  parameter int NINE_VAL = 9;

  typedef enum logic [1:0] {
    CTL_COUNT = 2'd0,
    CTL_ZERO  = 2'd1,
    CTL_NINE  = 2'd2
  } bq_ctl_e;
endpackage

// File: rtl/bq_fall_det.sv
module bq_fall_det #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] fall_o
);
  logic [N-1:0] prev_q;
  logic [N-1:0] prev_d;

  always_comb begin
    prev_d = lvl_i;
    fall_o = prev_q & ~lvl_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/bq_ctl_decode.sv
module bq_ctl_decode
  import bq_pkg::*;
(
  input  logic    clr0_a_i,
  input  logic    clr0_b_i,
  input  logic    set9_a_i,
  input  logic    set9_b_i,
  output bq_ctl_e ctl_o
);
  logic nine_req;
  logic zero_req;

  always_comb begin
    nine_req = set9_a_i & set9_b_i;
    zero_req = clr0_a_i & clr0_b_i;
    if (nine_req)      ctl_o = CTL_NINE;
    else if (zero_req) ctl_o = CTL_ZERO;
    else               ctl_o = CTL_COUNT;
  end
endmodule

// File: rtl/bq_modn.sv
module bq_modn
  import bq_pkg::*;
#(
  parameter int MOD    = 5,
  parameter int PRESET = 4,
  localparam int W     = (MOD > 1) ? $clog2(MOD) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ev_i,
  input  bq_ctl_e      ctl_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] TOP_V = W'(MOD - 1);
  localparam logic [W-1:0] PRE_V = W'(PRESET);

  logic [W-1:0] q_q;
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = 1'b0;
    q_d  = q_q;
    unique case (ctl_i)
      CTL_NINE: begin q_en = 1'b1; q_d = PRE_V; end
      CTL_ZERO: begin q_en = 1'b1; q_d = '0;    end
      default: begin
        q_en = ev_i;
        q_d  = (q_q >= TOP_V) ? '0 : q_q + W'(1);
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q_q <= '0;
    else if (q_en) q_q <= q_d;
  end

  assign q_o = q_q;

  p_step_r2_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i && ctl_i == CTL_COUNT && q_q < TOP_V) |=> (q_q == $past(q_q) + W'(1)));
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i && ctl_i == CTL_COUNT && q_q == TOP_V) |=> (q_q == '0));
  p_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!ev_i && ctl_i == CTL_COUNT) |=> $stable(q_q));
  p_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    q_q <= TOP_V);
endmodule

// File: rtl/bq_decade_counter.sv
module bq_decade_counter
  import bq_pkg::*;
#(
  parameter int MOD_LO = LO_MOD,
  parameter int MOD_HI = HI_MOD,
  parameter int PRE_V  = NINE_VAL,
  localparam int W_LO  = (MOD_LO > 1) ? $clog2(MOD_LO) : 1,
  localparam int W_HI  = (MOD_HI > 1) ? $clog2(MOD_HI) : 1,
  localparam int QW    = W_LO + W_HI
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_a_i,
  input  logic          cnt_b_i,
  input  logic          clr0_a_i,
  input  logic          clr0_b_i,
  input  logic          set9_a_i,
  input  logic          set9_b_i,
  output logic [QW-1:0] q_o
);
  logic [1:0] fall;
  bq_ctl_e    ctl;
  logic [W_LO-1:0] q_lo;
  logic [W_HI-1:0] q_hi;

  bq_fall_det #(.N(2)) u_fall (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  ({cnt_b_i, cnt_a_i}),
    .fall_o (fall)
  );

  bq_ctl_decode u_ctl (
    .clr0_a_i (clr0_a_i),
    .clr0_b_i (clr0_b_i),
    .set9_a_i (set9_a_i),
    .set9_b_i (set9_b_i),
    .ctl_o    (ctl)
  );

  bq_modn #(.MOD(MOD_LO), .PRESET(PRE_V % MOD_LO)) u_lo (
    .clk   (clk),
    .rst_n (rst_n),
    .ev_i  (fall[0]),
    .ctl_i (ctl),
    .q_o   (q_lo)
  );

  bq_modn #(.MOD(MOD_HI), .PRESET(PRE_V / MOD_LO)) u_hi (
    .clk   (clk),
    .rst_n (rst_n),
    .ev_i  (fall[1]),
    .ctl_i (ctl),
    .q_o   (q_hi)
  );

  assign q_o = {q_hi, q_lo};

  p_preset_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (set9_a_i && set9_b_i) |=> (q_o == QW'(PRE_V)));
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr0_a_i && clr0_b_i && !(set9_a_i && set9_b_i)) |=> (q_o == '0));
  p_reset_r1: assert property (@(posedge clk) !rst_n |-> (q_o == '0));
endmodule

// File: tb/bq_decade_counter_tb_top.sv
`timescale 1ns/1ps
module bq_decade_counter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic a_drv = 1'b0, b_drv = 1'b0;
  logic c0a = 1'b0, c0b = 1'b0, s9a = 1'b0, s9b = 1'b0;
  logic bcd_mode = 1'b0, sym_mode = 1'b0;
  logic [3:0] q;
  wire cnt_a = sym_mode ? q[3] : a_drv;
  wire cnt_b = bcd_mode ? q[0] : b_drv;

  int n_run = 0, n_fail = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_a = 0, m_b = 0, pa = 0, pb = 0;

  always #2.5 clk = ~clk;

  bq_decade_counter dut_i (
    .clk(clk), .rst_n(rst_n), .cnt_a_i(cnt_a), .cnt_b_i(cnt_b),
    .clr0_a_i(c0a), .clr0_b_i(c0b), .set9_a_i(s9a), .set9_b_i(s9b), .q_o(q)
  );

  function automatic logic [3:0] model_q();
    return {m_b[2:0], m_a[0]};
  endfunction

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: q_o=%b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // every cycle: compare, then step the model from the inputs the next edge samples
  always @(negedge clk) begin
    check(cur_req, q, model_q());
    if (!rst_n) begin
      m_a = 0; m_b = 0; pa = 0; pb = 0;
    end else begin
      automatic int fa = (pa == 1 && cnt_a == 1'b0);
      automatic int fb = (pb == 1 && cnt_b == 1'b0);
      if (s9a && s9b) begin m_a = 1; m_b = 4; end
      else if (c0a && c0b) begin m_a = 0; m_b = 0; end
      else begin
        if (fa != 0) m_a = 1 - m_a;
        if (fb != 0) m_b = (m_b + 1) % 5;
      end
      pa = int'(cnt_a); pb = int'(cnt_b);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse_a(input int hi, input int lo);
    a_drv = 1'b1; tick(hi); a_drv = 1'b0; tick(lo);
  endtask

  task automatic pulse_b(input int hi, input int lo);
    b_drv = 1'b1; tick(hi); b_drv = 1'b0; tick(lo);
  endtask

  task automatic clear_all();
    c0a = 1'b1; c0b = 1'b1; tick(1); c0a = 1'b0; c0b = 1'b0; tick(1);
  endtask

  task automatic report();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: run did not complete, q_o=%b expected done", q);
    report();
  end

  initial begin
    tick(3);
    cur_req = "R1";
    check("R1", q, 4'b0000);
    rst_n = 1'b1; tick(2);
    check("R1", q, 4'b0000);

    // R2: one-cycle and long pulses on A
    cur_req = "R2";
    for (int k = 1; k <= 6; k++) begin
      pulse_a((k % 3) + 1, (k % 2) + 1);
      check("R2", q, {3'b000, 1'(k % 2)});
    end

    // R3: B section sequence and wrap
    cur_req = "R3";
    clear_all();
    for (int k = 1; k <= 7; k++) begin
      pulse_b(k % 2 + 1, 2);
      check("R3", q, {3'(k % 5), 1'b0});
    end

    // R4: rising edges and held levels do nothing
    cur_req = "R4";
    clear_all();
    a_drv = 1'b1; b_drv = 1'b1; tick(6);
    check("R4", q, 4'b0000);
    a_drv = 1'b0; tick(2);
    check("R4", q, 4'b0001);
    b_drv = 1'b0; tick(4);
    check("R4", q, 4'b0011);

    // R5: clear; R7: single clear input does not block counting
    cur_req = "R5";
    c0a = 1'b1; c0b = 1'b1; tick(1);
    check("R5", q, 4'b0000);
    c0b = 1'b0; cur_req = "R7";
    pulse_a(1, 2);
    check("R7", q, 4'b0001);
    c0a = 1'b0;

    // R6: preset wins over clear
    cur_req = "R6";
    s9a = 1'b1; s9b = 1'b1; c0a = 1'b1; c0b = 1'b1; tick(1);
    check("R6", q, 4'b1001);
    // R7: events dropped while a pair is asserted
    cur_req = "R7";
    pulse_a(1, 1); pulse_b(1, 1);
    check("R7", q, 4'b1001);
    s9a = 1'b0; tick(1);
    check("R5", q, 4'b0000);
    pulse_a(1, 1);
    check("R7", q, 4'b0000);
    c0a = 1'b0; c0b = 1'b0; s9b = 1'b1;
    pulse_a(1, 2);
    check("R7", q, 4'b0001);
    s9b = 1'b0;

    // R8: BCD chaining
    cur_req = "R8";
    clear_all();
    bcd_mode = 1'b1;
    for (int k = 1; k <= 23; k++) begin
      pulse_a(2, 3);
      check("R8", q, 4'(k % 10));
    end
    bcd_mode = 1'b0;
    a_drv = 1'b0; tick(1);

    // R9: symmetric divide-by-ten
    cur_req = "R9";
    clear_all();
    sym_mode = 1'b1;
    for (int k = 1; k <= 20; k++) begin
      pulse_b(2, 3);
      check("R9", {3'b000, q[0]}, {3'b000, 1'((k / 5) % 2)});
    end
    sym_mode = 1'b0;
    tick(2);
    report();
  end
endmodule